// File: doc/BRIEF.md
# Programmable Video Raster Timing Generator

This block produces the raster timing for a single video stream. A horizontal counter runs over every clock of a line and a vertical counter advances once per line; from the two counts and a set of programmed attributes the block derives horizontal and vertical sync, a data-enable window, a one-cycle start-of-frame marker, an end-of-line marker and the coordinates of the current active pixel. A downstream framer uses these outputs to pace pixel data. The block carries no pixel data itself.

The attributes are line length, frame height, active width and height, sync widths, sync polarities and the offsets of the active region. Both offsets are measured from the leading edge of the matching sync pulse, which sits at count zero. Each sync output has its own polarity bit. Attributes arrive through a simple write port. Each write lands in a shadow copy. The shadow copy is moved into the working set only on the last clock of a frame, so every frame runs on one consistent set of values.

Top module: `vid_raster_gen`

## Requirements
- R1: While reset is held and right after it, both counters are zero and the working and shadow attribute sets hold the parameter defaults. With the defaults, hsync and vsync are both at their active level, and de and sof are low.
- R2: The horizontal count runs 0,1,…,htotal-1 and then returns to 0. eol is high exactly on the cycle where the count is htotal-1. An htotal of 0 or 1 makes every cycle a line end.
- R3: The vertical count advances by one on each line end and returns to 0 after the line end of line vtotal-1. A vtotal of 0 or 1 makes every line a frame end.
- R4: Sync is active while the horizontal count is below the horizontal sync width. The vertical sync follows the same rule against the vertical count, in lines.
- R5: Polarity bit 0 applies to hsync and bit 1 applies to vsync. A bit value of 0 drives the active level high and 1 drives it low.
- R6: de is high exactly when hstart ≤ hcount < hstart+hact and vstart ≤ vcount < vstart+vact. The sums are formed without wrap-around.
- R7: sof is high for the single cycle where de is high and the counts equal hstart and vstart.
- R8: While de is high, pix_x equals hcount-hstart and line_y equals vcount-vstart. Both are 0 while de is low.
- R9: A write changes only the shadow set. The shadow set is copied to the working set on the cycle where both counters end, and a write made in that same cycle is included in the copy.
- R10: The write addresses are 0 htotal, 1 hact, 2 hstart, 3 hsync width, 4 vtotal, 5 vact, 6 vstart, 7 vsync width and 8 polarity. The sync widths keep data bits [14:0], polarity keeps bits [1:0] and the other fields keep [15:0]. Writes to addresses 9 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_addr | input | 4 | Attribute write address |
| cfg_wdata | input | 16 | Attribute write data |
| hsync | output | 1 | Horizontal sync at the programmed polarity |
| vsync | output | 1 | Vertical sync at the programmed polarity |
| de | output | 1 | Active-region data enable |
| sof | output | 1 | Start-of-frame marker at the first active pixel |
| eol | output | 1 | Last clock of each line |
| pix_x | output | 16 | Active pixel column, 0 outside the active region |
| line_y | output | 16 | Active line row, 0 outside the active region |

## Verification
The bench targets writes made in the middle of a frame and writes made in the very last cycle of a frame. A design that applied attributes at once would change the sync widths or the line length in the middle of a frame, and a design that lost a write made at the boundary would run one frame late. It also drives degenerate totals of 0 and 1, sync widths wider than the line, active windows that run past the total, and all four polarity combinations. A wrong wrap compare there would stall the counters or skip a line, and a swapped polarity bit would invert the wrong sync output. Oversized writes and writes to unmapped addresses check that the field widths are truncated and that stray addresses leave the timing unchanged.

// File: rtl/vrg_pkg.sv
package vrg_pkg;

    localparam int VRG_CW = 16;   // count width
    localparam int VRG_SW = 15;   // sync width field
    localparam int VRG_PW = 2;    // polarity bits
    localparam int VRG_AW = 4;    // write address width

    typedef struct packed {
        logic [VRG_CW-1:0] htotal;
        logic [VRG_CW-1:0] hact;
        logic [VRG_CW-1:0] hstart;
        logic [VRG_SW-1:0] hsw;
        logic [VRG_CW-1:0] vtotal;
        logic [VRG_CW-1:0] vact;
        logic [VRG_CW-1:0] vstart;
        logic [VRG_SW-1:0] vsw;
        logic [VRG_PW-1:0] pol;
    } vrg_timing_t;

    typedef enum logic [VRG_AW-1:0] {
        A_HTOTAL = 4'd0,
        A_HACT   = 4'd1,
        A_HSTART = 4'd2,
        A_HSW    = 4'd3,
        A_VTOTAL = 4'd4,
        A_VACT   = 4'd5,
        A_VSTART = 4'd6,
        A_VSW    = 4'd7,
        A_POL    = 4'd8
    } vrg_addr_e;

endpackage

// File: rtl/vrg_cfg_bank.sv
module vrg_cfg_bank
    import vrg_pkg::*;
#(
    parameter vrg_timing_t RESET_CFG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [VRG_AW-1:0] addr,
    input  logic [VRG_CW-1:0] wdata,
    input  logic              frame_end,
    output vrg_timing_t       active
);

    typedef struct packed {
        vrg_timing_t shadow;
        vrg_timing_t work;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            case (addr)
                A_HTOTAL: bank_d.shadow.htotal = wdata;
                A_HACT:   bank_d.shadow.hact   = wdata;
                A_HSTART: bank_d.shadow.hstart = wdata;
                A_HSW:    bank_d.shadow.hsw    = wdata[VRG_SW-1:0];
                A_VTOTAL: bank_d.shadow.vtotal = wdata;
                A_VACT:   bank_d.shadow.vact   = wdata;
                A_VSTART: bank_d.shadow.vstart = wdata;
                A_VSW:    bank_d.shadow.vsw    = wdata[VRG_SW-1:0];
                A_POL:    bank_d.shadow.pol    = wdata[VRG_PW-1:0];
                default:  ;
            endcase
        end
        if (frame_end) begin
            bank_d.work = bank_d.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '{shadow: RESET_CFG, work: RESET_CFG};
        end else begin
            bank_q <= bank_d;
        end
    end

    assign active = bank_q.work;

    // R9: the working set only moves at a frame boundary
    p_hold_midframe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(active));

endmodule

// File: rtl/vrg_counters.sv
module vrg_counters
    import vrg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VRG_CW-1:0] htotal,
    input  logic [VRG_CW-1:0] vtotal,
    output logic [VRG_CW-1:0] hcnt,
    output logic [VRG_CW-1:0] vcnt,
    output logic              hwrap,
    output logic              vwrap
);

    typedef struct packed {
        logic [VRG_CW-1:0] h;
        logic [VRG_CW-1:0] v;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        hwrap = ({1'b0, cnt_q.h} + 1'b1) >= {1'b0, htotal};
        vwrap = ({1'b0, cnt_q.v} + 1'b1) >= {1'b0, vtotal};
        cnt_d = cnt_q;
        if (hwrap) begin
            cnt_d.h = '0;
            if (vwrap) begin
                cnt_d.v = '0;
            end else begin
                cnt_d.v = cnt_q.v + 1'b1;
            end
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hcnt = cnt_q.h;
    assign vcnt = cnt_q.v;

    p_hcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == '0) || (hcnt < htotal));

    p_line_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hwrap |=> (hcnt == '0));

    p_vstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hwrap && !vwrap) |=> (vcnt == $past(vcnt) + 1'b1));

    p_vhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hwrap |=> $stable(vcnt));

endmodule

// File: rtl/vrg_decode.sv
module vrg_decode
    import vrg_pkg::*;
(
    input  vrg_timing_t       cfg,
    input  logic [VRG_CW-1:0] hcnt,
    input  logic [VRG_CW-1:0] vcnt,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              sof,
    output logic [VRG_CW-1:0] pix_x,
    output logic [VRG_CW-1:0] line_y
);

    logic [VRG_CW:0] h_end, v_end;
    logic            h_in, v_in, hs_on, vs_on;

    always_comb begin
        h_end = {1'b0, cfg.hstart} + {1'b0, cfg.hact};
        v_end = {1'b0, cfg.vstart} + {1'b0, cfg.vact};
        h_in  = (hcnt >= cfg.hstart) && ({1'b0, hcnt} < h_end);
        v_in  = (vcnt >= cfg.vstart) && ({1'b0, vcnt} < v_end);
        hs_on = hcnt < {1'b0, cfg.hsw};
        vs_on = vcnt < {1'b0, cfg.vsw};
        hsync = hs_on ^ cfg.pol[0];
        vsync = vs_on ^ cfg.pol[1];
        de    = h_in && v_in;
        sof   = de && (hcnt == cfg.hstart) && (vcnt == cfg.vstart);
        pix_x  = de ? (hcnt - cfg.hstart) : '0;
        line_y = de ? (vcnt - cfg.vstart) : '0;
    end

endmodule

// File: rtl/vid_raster_gen.sv
module vid_raster_gen #(
    parameter int DEF_HTOTAL = 12,
    parameter int DEF_HACT   = 6,
    parameter int DEF_HSTART = 3,
    parameter int DEF_HSW    = 2,
    parameter int DEF_VTOTAL = 8,
    parameter int DEF_VACT   = 4,
    parameter int DEF_VSTART = 2,
    parameter int DEF_VSW    = 1,
    parameter int DEF_POL    = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    output logic        hsync,
    output logic        vsync,
    output logic        de,
    output logic        sof,
    output logic        eol,
    output logic [15:0] pix_x,
    output logic [15:0] line_y
);
    import vrg_pkg::*;

    localparam vrg_timing_t DEF_CFG = '{
        htotal: VRG_CW'(DEF_HTOTAL),
        hact:   VRG_CW'(DEF_HACT),
        hstart: VRG_CW'(DEF_HSTART),
        hsw:    VRG_SW'(DEF_HSW),
        vtotal: VRG_CW'(DEF_VTOTAL),
        vact:   VRG_CW'(DEF_VACT),
        vstart: VRG_CW'(DEF_VSTART),
        vsw:    VRG_SW'(DEF_VSW),
        pol:    VRG_PW'(DEF_POL)
    };

    vrg_timing_t       act_cfg;
    logic [VRG_CW-1:0] hcnt, vcnt;
    logic              hwrap, vwrap, frame_end;

    assign frame_end = hwrap && vwrap;

    vrg_cfg_bank #(.RESET_CFG(DEF_CFG)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .frame_end (frame_end),
        .active    (act_cfg)
    );

    vrg_counters i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .htotal (act_cfg.htotal),
        .vtotal (act_cfg.vtotal),
        .hcnt   (hcnt),
        .vcnt   (vcnt),
        .hwrap  (hwrap),
        .vwrap  (vwrap)
    );

    vrg_decode i_dec (
        .cfg    (act_cfg),
        .hcnt   (hcnt),
        .vcnt   (vcnt),
        .hsync  (hsync),
        .vsync  (vsync),
        .de     (de),
        .sof    (sof),
        .pix_x  (pix_x),
        .line_y (line_y)
    );

    assign eol = hwrap;

    p_sof_in_de_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> de);

    p_sof_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && !frame_end) |=> !sof);

    p_coord_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (pix_x == '0 && line_y == '0));

    p_sof_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (pix_x == '0 && line_y == '0));

endmodule

// File: tb/test_vid_raster_gen.sv
module test_vid_raster_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        hsync, vsync, de, sof, eol;
    logic [15:0] pix_x, line_y;

    int n_checks = 0;
    int n_bad    = 0;
    int cycles   = 0;
    bit finished = 1'b0;
    string phase = "R1";

    // model state: index order follows the write addresses of R10
    int m_act[9];
    int m_sh[9];
    int m_h, m_v;
    int defaults[9] = '{12, 6, 3, 2, 8, 4, 2, 1, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_raster_gen i_vid_raster_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .de(de),
        .sof(sof), .eol(eol), .pix_x(pix_x), .line_y(line_y)
    );

    function automatic int field_mask(int a, int d);
        if (a == 3 || a == 7) return d & 32'h7FFF;
        if (a == 8) return d & 3;
        return d & 32'hFFFF;
    endfunction

    function automatic bit m_hwrap();
        return (m_h + 1) >= m_act[0];
    endfunction

    function automatic bit m_vwrap();
        return (m_v + 1) >= m_act[4];
    endfunction

    // reference model step (R2, R3, R9, R10)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_h = 0; m_v = 0;
            for (int i = 0; i < 9; i++) begin
                m_act[i] = defaults[i];
                m_sh[i]  = defaults[i];
            end
        end else begin
            bit hw, vw;
            hw = m_hwrap();
            vw = m_vwrap();
            if (cfg_we && cfg_addr < 9)
                m_sh[cfg_addr] = field_mask(int'(cfg_addr), int'(cfg_wdata));
            if (hw && vw)
                for (int i = 0; i < 9; i++) m_act[i] = m_sh[i];
            if (hw) begin
                m_h = 0;
                m_v = vw ? 0 : m_v + 1;
            end else begin
                m_h = m_h + 1;
            end
        end
    end

    task automatic chk(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) at cycle %0d: got=%0d expected=%0d",
                     req, phase, cycles, got, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit in_h, in_v, e_de;
            in_h = m_h >= m_act[2] && m_h < m_act[2] + m_act[1];
            in_v = m_v >= m_act[6] && m_v < m_act[6] + m_act[5];
            e_de = in_h && in_v;
            chk("R4 R5 hsync", int'(hsync), int'(m_h < m_act[3]) ^ (m_act[8] & 1));
            chk("R3 R4 R5 vsync", int'(vsync), int'(m_v < m_act[7]) ^ ((m_act[8] >> 1) & 1));
            chk("R2 eol", int'(eol), int'(m_hwrap()));
            chk("R3 R6 de", int'(de), int'(e_de));
            chk("R7 sof", int'(sof), int'(e_de && m_h == m_act[2] && m_v == m_act[6]));
            chk("R8 pix_x", int'(pix_x), e_de ? m_h - m_act[2] : 0);
            chk("R8 line_y", int'(line_y), e_de ? m_v - m_act[6] : 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: got=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        // R1: reset state with the defaults
        chk("R1 hsync", int'(hsync), 1);
        chk("R1 vsync", int'(vsync), 1);
        chk("R1 de", int'(de), 0);
        chk("R1 sof", int'(sof), 0);
        chk("R1 pix_x", int'(pix_x), 0);
        rst_n = 1'b1;
        idle(2 * 12 * 8 + 5);

        // R9: a full new timing written in the middle of a frame
        phase = "R9";
        idle(30);
        wr(0, 16); wr(1, 9); wr(2, 5); wr(3, 4);
        wr(4, 10); wr(5, 5); wr(6, 3); wr(7, 2);
        idle(3 * 16 * 10);

        // R5: each polarity combination
        phase = "R5";
        for (int p = 1; p < 4; p++) begin
            wr(8, p);
            idle(2 * 16 * 10);
        end

        // R10: oversized fields and unmapped addresses
        phase = "R10";
        wr(3, 16'hFFFF); wr(8, 16'hFFFC);
        for (int a = 9; a < 16; a++) wr(a, 16'h0001);
        idle(2 * 16 * 10);
        wr(3, 3);

        // R2 R3: degenerate totals and windows past the total
        phase = "R2 R3";
        wr(0, 1); wr(4, 3); wr(1, 4); wr(2, 0);
        idle(40);
        wr(0, 0); wr(4, 0);
        idle(20);
        wr(0, 7); wr(4, 1); wr(2, 5); wr(1, 9); wr(6, 0); wr(5, 3);
        idle(60);
        wr(4, 6); wr(6, 4); wr(5, 40000);
        idle(200);

        // R9: random writes, including ones that fall on the frame boundary
        phase = "R9 random";
        for (int k = 0; k < 30000; k++) begin
            @(negedge clk);
            if ($urandom_range(0, 5) == 0) begin
                int a, d;
                a = $urandom_range(0, 15);
                case (a)
                    0, 1, 2, 3: d = $urandom_range(0, 20);
                    4, 5, 6, 7: d = $urandom_range(0, 10);
                    default:    d = $urandom_range(0, 16'hFFFF);
                endcase
                if ($urandom_range(0, 30) == 0) d = 16'hFFFF;
                cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
            end else begin
                cfg_we = 1'b0;
            end
        end
        cfg_we = 1'b0;
        idle(500);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule